// File: doc/BRIEF.md
# Legacy Shadow Segment Router

This block decides where a memory access into the legacy area just below 1 MB is sent. The area holds thirteen segments: one 64 KB firmware segment at the top and twelve 16 KB expansion segments below it. Each segment has two attribute bits, one for reads and one for writes. Each bit sends that direction either to DRAM (bit set) or to the PCI bus (bit cleared). The attributes are held in seven byte-wide registers. The firmware segment uses half of the first register, and each later register holds the nibbles of two expansion segments.

A requester presents an address and a direction. One cycle later the block returns whether the address lies in any segment, which segment it is, and whether the access goes to DRAM. Configuration software writes the attribute registers through a 32-bit word port with byte enables. A change to the attributes is copied into a per-segment routing table in one step, so no lookup ever sees a mix of old and new routing.

Top module: `shadow_route_decoder`

## Requirements
- R1: After reset every attribute register is zero, so every segment routes both reads and writes to PCI (`rsp_dram` = 0), and `rsp_valid` and `rsp_claimed` are 0.
- R2: Addresses 0xF0000 to 0xFFFFF form segment 0. Its attributes are bits 7:4 of register 0. Bits 3:0 of register 0 affect no routing.
- R3: Expansion segment k (k = 1 to 12) covers 0xC0000 + (k-1)*0x4000 up to 0x3FFF bytes above that. It is reported as `rsp_seg` = k.
- R4: Segment i reads register (i+1)/2 (integer division). An odd i uses bits 3:0 of that register and an even i uses bits 7:4.
- R5: In a segment's nibble, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. A cleared bit sends that direction to PCI. Bits 2 and 3 of the nibble have no effect.
- R6: An address below 0xC0000 is not claimed. The response then has `rsp_claimed` = 0, `rsp_dram` = 0 and `rsp_seg` = 15.
- R7: Register k sits at word `k>>2`, byte lane `k&3` (lane 0 is bits 7:0). A write changes only the lanes whose `cfg_be` bit is set. Lane 3 of word 1 holds no register, and writes to it are ignored.
- R8: A request sampled at a clock edge with `req_valid` high gives its response at that same edge, with `rsp_valid` = 1. After an edge with `req_valid` low, `rsp_valid` is 0.
- R9: A configuration write sampled at edge E updates all segments' routing together. A request sampled at E+1 still sees the old routing of every segment. A request sampled at E+2 or later sees the new routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 1 | Word index of the attribute register file |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 20 | Byte address of the access |
| req_write | input | 1 | Access direction, 1 = write |
| rsp_valid | output | 1 | Response valid |
| rsp_claimed | output | 1 | Address lies inside a segment |
| rsp_dram | output | 1 | 1 = route to DRAM, 0 = route to PCI |
| rsp_seg | output | 4 | Segment number, 15 when not claimed |

## Verification
The hardest situation to reach is the instant just after a write: the registers have changed but the routing table has not yet been reloaded. That one cycle is reached by asserting a request on the edge right after the write strobe, and the bench checks there that the old routing is still in force. It then checks the new routing on the following edge, once for the firmware segment and once for an expansion segment. Beyond that, whole-area sweeps at 1 KB steps, run for both directions under many register patterns, cover every segment boundary and every nibble choice. These patterns include partial-lane writes and writes to the unmapped lane.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = 4;
  localparam int unsigned NIB_W   = 4;

  // attribute nibble bit positions
  localparam int unsigned RD_BIT  = 0;
  localparam int unsigned WR_BIT  = 1;

  typedef struct packed {
    logic wr_dram;
    logic rd_dram;
  } route_t;

  function automatic route_t nib_to_route(input logic [NIB_W-1:0] nib);
    route_t r;
    r.rd_dram = nib[RD_BIT];
    r.wr_dram = nib[WR_BIT];
    return r;
  endfunction

endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
  import shadow_pkg::*;
#(
  parameter int unsigned REG_COUNT = 7,
  parameter int unsigned WORD_W    = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [WORD_W-1:0]           word,
  input  logic [LANES-1:0]            be,
  input  logic [LANES*LANE_W-1:0]     wdata,
  output logic [REG_COUNT*LANE_W-1:0] regs_flat,
  output logic                        changed
);

  logic [REG_COUNT-1:0] hit;

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
    localparam int unsigned WIDX = k / LANES;
    localparam int unsigned LIDX = k % LANES;
    logic [LANE_W-1:0] r;

    assign hit[k] = wr_en && (int'(word) == WIDX) && be[LIDX];

    always_ff @(posedge clk) begin
      if (rst)         r <= '0;
      else if (hit[k]) r <= wdata[LIDX*LANE_W +: LANE_W];
    end

    assign regs_flat[k*LANE_W +: LANE_W] = r;
  end

  always_ff @(posedge clk) begin
    if (rst) changed <= 1'b0;
    else     changed <= |hit;
  end

  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_flat));

  // R7
  be_none_chk: assert property (@(posedge clk) disable iff (rst)
    (be == '0) |=> $stable(regs_flat));

endmodule

// File: rtl/shadow_route_table.sv
module shadow_route_table
  import shadow_pkg::*;
#(
  parameter int unsigned SEG_COUNT = 13,
  parameter int unsigned REG_COUNT = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [REG_COUNT*LANE_W-1:0] regs_flat,
  input  logic                        reload,
  output logic [SEG_COUNT-1:0]        rd_dram,
  output logic [SEG_COUNT-1:0]        wr_dram
);

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
    localparam int unsigned RIDX = (i + 1) / 2;
    localparam int unsigned NOFF = (i % 2 == 1) ? 0 : NIB_W;
    logic [NIB_W-1:0] nib;
    route_t           rt;

    assign nib = regs_flat[RIDX*LANE_W + NOFF +: NIB_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        rt <= '0;
      end else if (reload) begin
        rt <= nib_to_route(nib);
      end
    end

    assign rd_dram[i] = rt.rd_dram;
    assign wr_dram[i] = rt.wr_dram;
  end

  logic unused_lo_nib;
  assign unused_lo_nib = ^{regs_flat[NIB_W-1:0],
                           regs_flat[REG_COUNT*LANE_W-1 -: 2]};

  // R9
  table_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    !reload |=> ($stable(rd_dram) && $stable(wr_dram)));

  // R9
  table_follow_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> ((rd_dram[0] == $past(regs_flat[NIB_W + RD_BIT]))
             && (wr_dram[0] == $past(regs_flat[NIB_W + WR_BIT]))));

endmodule

// File: rtl/shadow_seg_lookup.sv
module shadow_seg_lookup #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BIOS_BASE = 32'hF0000,
  parameter int unsigned BIOS_LG2  = 16,
  parameter int unsigned EXP_BASE  = 32'hC0000,
  parameter int unsigned EXP_LG2   = 14,
  parameter int unsigned EXP_SEGS  = 12,
  parameter int unsigned SEG_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEG_W-1:0]  seg
);

  localparam int unsigned EXP_TOP = EXP_BASE + (EXP_SEGS << EXP_LG2);

  logic [31:0] a32;
  logic [31:0] off;
  logic [31:0] idx;
  logic        in_bios;
  logic        in_exp;

  always_comb begin
    a32     = 32'(addr);
    off     = a32 - EXP_BASE;
    idx     = off >> EXP_LG2;
    in_bios = (a32 >> BIOS_LG2) == (BIOS_BASE >> BIOS_LG2);
    in_exp  = (a32 >= EXP_BASE) && (a32 < EXP_TOP);
    hit     = in_bios || in_exp;
    if (in_bios)     seg = '0;
    else if (in_exp) seg = SEG_W'(idx + 32'd1);
    else             seg = '1;
  end

endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BIOS_BASE = 32'hF0000,
  parameter int unsigned BIOS_LG2  = 16,
  parameter int unsigned EXP_BASE  = 32'hC0000,
  parameter int unsigned EXP_LG2   = 14,
  parameter int unsigned EXP_SEGS  = 12,
  localparam int unsigned SEG_COUNT = EXP_SEGS + 1,
  localparam int unsigned REG_COUNT = (SEG_COUNT + 1) / 2,
  localparam int unsigned WORDS     = (REG_COUNT + LANES - 1) / LANES,
  localparam int unsigned WORD_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned SEG_W     = $clog2(SEG_COUNT + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_wr,
  input  logic [WORD_W-1:0]       cfg_word,
  input  logic [LANES-1:0]        cfg_be,
  input  logic [LANES*LANE_W-1:0] cfg_wdata,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  output logic                    rsp_valid,
  output logic                    rsp_claimed,
  output logic                    rsp_dram,
  output logic [SEG_W-1:0]        rsp_seg
);

  localparam int unsigned SEG_PAD = 1 << SEG_W;

  logic [REG_COUNT*LANE_W-1:0] regs_flat;
  logic                        reload;
  logic [SEG_COUNT-1:0]        rd_dram;
  logic [SEG_COUNT-1:0]        wr_dram;
  logic [SEG_PAD-1:0]          rd_pad;
  logic [SEG_PAD-1:0]          wr_pad;
  logic                        lk_hit;
  logic [SEG_W-1:0]            lk_seg;
  logic                        sel_dram;

  shadow_attr_regs #(
    .REG_COUNT (REG_COUNT),
    .WORD_W    (WORD_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr),
    .word      (cfg_word),
    .be        (cfg_be),
    .wdata     (cfg_wdata),
    .regs_flat (regs_flat),
    .changed   (reload)
  );

  shadow_route_table #(
    .SEG_COUNT (SEG_COUNT),
    .REG_COUNT (REG_COUNT)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .regs_flat (regs_flat),
    .reload    (reload),
    .rd_dram   (rd_dram),
    .wr_dram   (wr_dram)
  );

  shadow_seg_lookup #(
    .ADDR_W    (ADDR_W),
    .BIOS_BASE (BIOS_BASE),
    .BIOS_LG2  (BIOS_LG2),
    .EXP_BASE  (EXP_BASE),
    .EXP_LG2   (EXP_LG2),
    .EXP_SEGS  (EXP_SEGS),
    .SEG_W     (SEG_W)
  ) u_lookup (
    .addr      (req_addr),
    .hit       (lk_hit),
    .seg       (lk_seg)
  );

  assign rd_pad   = {{(SEG_PAD-SEG_COUNT){1'b0}}, rd_dram};
  assign wr_pad   = {{(SEG_PAD-SEG_COUNT){1'b0}}, wr_dram};
  assign sel_dram = lk_hit && (req_write ? wr_pad[lk_seg] : rd_pad[lk_seg]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_claimed <= 1'b0;
      rsp_dram    <= 1'b0;
      rsp_seg     <= '1;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_claimed <= lk_hit;
        rsp_dram    <= sel_dram;
        rsp_seg     <= lk_seg;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R6
  miss_pci_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_claimed) |-> (!rsp_dram && (rsp_seg == '1)));

  // R3
  seg_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_claimed) |-> (32'(rsp_seg) < SEG_COUNT));

  // R2
  bios_seg_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && (32'(req_addr) >= BIOS_BASE)
      |=> (rsp_claimed && (rsp_seg == '0)));

endmodule

// File: tb/sim_shadow_route_decoder.sv
module sim_shadow_route_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [0:0]  cfg_word = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_claimed, rsp_dram;
  logic [3:0]  rsp_seg;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [7:0] m [0:6];

  always #2 clk = ~clk;

  shadow_route_decoder u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_claimed(rsp_claimed), .rsp_dram(rsp_dram), .rsp_seg(rsp_seg)
  );

  // expected routing from the requirements (R2 R3 R4 R5 R6)
  task automatic model(input int addr, input bit wr,
                       output bit c, output bit d, output int s);
    logic [7:0] r;
    logic [3:0] nib;
    if (addr >= 32'hF0000)      s = 0;
    else if (addr >= 32'hC0000) s = ((addr - 32'hC0000) / 16384) + 1;
    else                        s = 15;
    c = (s != 15);
    d = 1'b0;
    if (c) begin
      r   = m[(s + 1) / 2];
      nib = (s % 2 == 1) ? r[3:0] : r[7:4];
      d   = wr ? nib[1] : nib[0];
    end
  endtask

  task automatic cmp(input string tag, input int addr, input bit wr,
                     input bit c, input bit d, input int s);
    tests++;
    if (rsp_valid !== 1'b1 || rsp_claimed !== c || rsp_dram !== d ||
        int'(rsp_seg) != s) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0d got v=%0d c=%0d d=%0d s=%0d exp v=1 c=%0d d=%0d s=%0d",
               tag, addr, wr, rsp_valid, rsp_claimed, rsp_dram, rsp_seg, c, d, s);
    end
  endtask

  task automatic cfg_write(input bit w, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w; cfg_be = be; cfg_wdata = data;
    for (int l = 0; l < 4; l++) begin
      if (be[l] && (w * 4 + l) < 7) m[w * 4 + l] = data[l*8 +: 8];
    end
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic sweep(input string lbl);
    bit c, d; int s;
    for (int a = 0; a < 1024; a++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        req_valid = 1'b1; req_addr = 20'(a << 10); req_write = w[0];
        @(posedge clk); #1;
        model(a << 10, w[0], c, d, s);
        if (!c)         cmp({lbl, " R6 R8"}, a << 10, w[0], c, d, s);
        else if (s == 0) cmp({lbl, " R2 R5"}, a << 10, w[0], c, d, s);
        else             cmp({lbl, " R3 R4 R5"}, a << 10, w[0], c, d, s);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // R9: request on the edge after the write sees old routing, next edge new
  task automatic atomic_probe(input int addr, input bit w,
                              input logic [3:0] be, input logic [31:0] data);
    bit c0, d0, c1, d1; int s0, s1;
    model(addr, 1'b0, c0, d0, s0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w; cfg_be = be; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
    for (int l = 0; l < 4; l++) begin
      if (be[l] && (w * 4 + l) < 7) m[w * 4 + l] = data[l*8 +: 8];
    end
    model(addr, 1'b0, c1, d1, s1);
    req_valid = 1'b1; req_addr = 20'(addr); req_write = 1'b0;
    @(posedge clk); #1;
    cmp("R9 old", addr, 1'b0, c0, d0, s0);
    @(posedge clk); #1;
    cmp("R9 new", addr, 1'b0, c1, d1, s1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 7; k++) m[k] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R1
    tests++;
    if (rsp_valid !== 1'b0 || rsp_claimed !== 1'b0 || rsp_dram !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs got v=%0d c=%0d d=%0d exp 0 0 0",
               rsp_valid, rsp_claimed, rsp_dram);
    end
    sweep("R1");

    // R8: idle after a request
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8 idle rsp_valid got %0d exp 0", rsp_valid);
    end

    // full-register patterns; lane 3 of word 1 gets junk (R7)
    for (int p = 0; p < 8; p++) begin
      logic [31:0] w0, w1;
      for (int l = 0; l < 4; l++) begin
        w0[l*8 +: 8] = 8'((p * 37 + l * 91 + 5) ^ (p << 4));
        w1[l*8 +: 8] = 8'((p * 53 + l * 29 + 11) ^ (l << 6));
      end
      cfg_write(1'b0, 4'hF, w0);
      cfg_write(1'b1, 4'hF, w1);
      sweep("R7 pattern");
    end

    // R7: partial lane write touches only register 2
    cfg_write(1'b0, 4'b0100, 32'hA5_96_3C_C3);
    sweep("R7 lane");
    // R7: unmapped lane alone changes nothing
    cfg_write(1'b1, 4'b1000, 32'hFF_00_00_00);
    sweep("R7 unmapped");

    // R9 on firmware segment and on an expansion segment
    cfg_write(1'b0, 4'hF, 32'h0);
    atomic_probe(32'hF4000, 1'b0, 4'hF, 32'h33_33_33_33);
    atomic_probe(32'hD0000, 1'b0, 4'b1000, 32'h00_00_00_00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule